// File: doc/BRIEF.md
# Conditional-Sum Adder Tree

This block adds two unsigned operands and an incoming carry without any carry chain. Each bit position first works out two outcomes side by side: what its sum and carry would be if a carry of 0 arrived, and what they would be if a carry of 1 arrived. Neighbouring groups are then joined in pairs, with group sizes doubling from 1 to 2, 4 and 8 bits. At each join the lower group keeps its bits as they are. For each of the two assumptions, the carry that the lower group produces under that assumption picks one of the two precomputed versions of the upper group.

After the last join the block holds two complete results, one for an incoming carry of 0 and one for 1. The real carry-in then chooses between them. The delay grows with the logarithm of the width, not linearly. The block is purely combinational and is meant to sit in a wider datapath wherever a fast add is needed between registers.

Top module: `cond_sum_adder`

## Requirements
- R1: For every operand pair and carry-in, the concatenation {cout, sum} equals a + b + cin, read as unsigned integers with cin weighted 1.
- R2: With cin = 0, sum equals the low WIDTH bits of a + b and cout equals bit WIDTH of a + b.
- R3: With cin = 1, sum equals the low WIDTH bits of a + b + 1 and cout equals bit WIDTH of that total.
- R4: For any fixed operand pair, cout with cin = 1 is never 0 while cout with cin = 0 is 1.
- R5: The two final carries differ only when a + b equals all ones. In that case cin = 1 gives a sum of all zeros with cout = 1.
- R6: Operands a = 8'b00101101 and b = 8'b10110110 give sum 8'b11100011 with cout 0 when cin = 0, and sum 8'b11100100 with cout 0 when cin = 1.
- R7: The outputs depend only on the present inputs. They hold no state and need no clock, so they are valid within the same time step as an input change.
- R8: The two precomputed final sums always differ by exactly one, modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Incoming carry that picks the final result |
| sum | output | WIDTH | Low WIDTH bits of the total |
| cout | output | 1 | Carry out of the top bit |

## Verification
The checker watches every input change. On each one it compares the port result with a behavioural addition, and it checks the two internal final results against each other: the carry for hypothesis 1 never falls below the carry for hypothesis 0, the two sums differ by one, and the carries split only on an all-ones sum. The worked operand pair and the absence of any stored state show only in the bench's scenarios. The bench also sweeps every combination of both operands and the carry-in. For each operand pair it compares the two carry-in cases against each other at the ports.

// File: rtl/csa_pkg.sv
package csa_pkg;

    localparam int unsigned CSA_DEF_WIDTH = 8;

    // Index of the carry hypothesis a precomputed result belongs to.
    typedef enum logic {
        HYP_C0 = 1'b0,
        HYP_C1 = 1'b1
    } csa_hyp_e;

    // True when w is a power of two no smaller than 2.
    function automatic bit csa_width_ok(input int unsigned w);
        return (w >= 2) && ((w & (w - 1)) == 0);
    endfunction

    // Number of merge levels for a power-of-two width.
    function automatic int unsigned csa_levels(input int unsigned w);
        int unsigned n;
        n = 0;
        while ((1 << n) < w) n++;
        return n;
    endfunction

endpackage

// File: rtl/csa_leaf.sv
module csa_leaf #(
    parameter int unsigned WIDTH = csa_pkg::CSA_DEF_WIDTH
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] s0,
    output logic [WIDTH-1:0] s1,
    output logic [WIDTH-1:0] c0,
    output logic [WIDTH-1:0] c1
);
    // One-bit groups, both carry assumptions per position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic half;
        assign half  = a[i] ^ b[i];
        assign s0[i] = half;
        assign s1[i] = ~half;
        assign c0[i] = a[i] & b[i];
        assign c1[i] = a[i] | b[i];
    end
endmodule

// File: rtl/csa_merge.sv
module csa_merge #(
    parameter int unsigned HALF = 1
) (
    input  logic [HALF-1:0]   lo_s0,
    input  logic [HALF-1:0]   lo_s1,
    input  logic              lo_c0,
    input  logic              lo_c1,
    input  logic [HALF-1:0]   hi_s0,
    input  logic [HALF-1:0]   hi_s1,
    input  logic              hi_c0,
    input  logic              hi_c1,
    output logic [2*HALF-1:0] s0,
    output logic [2*HALF-1:0] s1,
    output logic              c0,
    output logic              c1
);
    // Lower half passes through; its conditional carry picks the upper version.
    always_comb begin
        s0 = {(lo_c0 ? hi_s1 : hi_s0), lo_s0};
        c0 =  lo_c0 ? hi_c1 : hi_c0;
        s1 = {(lo_c1 ? hi_s1 : hi_s0), lo_s1};
        c1 =  lo_c1 ? hi_c1 : hi_c0;
    end
endmodule

// File: rtl/csa_pick.sv
module csa_pick #(
    parameter int unsigned WIDTH = csa_pkg::CSA_DEF_WIDTH
) (
    input  logic [WIDTH-1:0] s0,
    input  logic [WIDTH-1:0] s1,
    input  logic             c0,
    input  logic             c1,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    import csa_pkg::*;

    csa_hyp_e sel;

    always_comb begin
        sel  = csa_hyp_e'(cin);
        sum  = (sel == HYP_C1) ? s1 : s0;
        cout = (sel == HYP_C1) ? c1 : c0;
    end
endmodule

// File: rtl/cond_sum_adder.sv
module cond_sum_adder #(
    parameter int unsigned WIDTH = csa_pkg::CSA_DEF_WIDTH
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int unsigned LEVELS = csa_pkg::csa_levels(WIDTH);

    initial begin
        if (!csa_pkg::csa_width_ok(WIDTH))
            $error("cond_sum_adder: WIDTH must be a power of two >= 2");
    end

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int unsigned NG = WIDTH >> l;   // groups at this level
        localparam int unsigned GS = 1 << l;       // bits per group
        logic [WIDTH-1:0] s0, s1;
        logic [NG-1:0]    c0, c1;

        if (l == 0) begin : g_leaf
            csa_leaf #(.WIDTH(WIDTH)) u_leaf (
                .a  (a),
                .b  (b),
                .s0 (s0),
                .s1 (s1),
                .c0 (c0),
                .c1 (c1)
            );
        end else begin : g_join
            localparam int unsigned HS = GS / 2;
            for (genvar g = 0; g < NG; g++) begin : g_grp
                csa_merge #(.HALF(HS)) u_merge (
                    .lo_s0 (g_lvl[l-1].s0[g*GS +: HS]),
                    .lo_s1 (g_lvl[l-1].s1[g*GS +: HS]),
                    .lo_c0 (g_lvl[l-1].c0[2*g]),
                    .lo_c1 (g_lvl[l-1].c1[2*g]),
                    .hi_s0 (g_lvl[l-1].s0[g*GS+HS +: HS]),
                    .hi_s1 (g_lvl[l-1].s1[g*GS+HS +: HS]),
                    .hi_c0 (g_lvl[l-1].c0[2*g+1]),
                    .hi_c1 (g_lvl[l-1].c1[2*g+1]),
                    .s0    (s0[g*GS +: GS]),
                    .s1    (s1[g*GS +: GS]),
                    .c0    (c0[g]),
                    .c1    (c1[g])
                );
            end
        end
    end

    // Two complete results, one per carry hypothesis.
    logic [WIDTH-1:0] fin_s0, fin_s1;
    logic             fin_c0, fin_c1;

    assign fin_s0 = g_lvl[LEVELS].s0;
    assign fin_s1 = g_lvl[LEVELS].s1;
    assign fin_c0 = g_lvl[LEVELS].c0[0];
    assign fin_c1 = g_lvl[LEVELS].c1[0];

    csa_pick #(.WIDTH(WIDTH)) u_pick (
        .s0   (fin_s0),
        .s1   (fin_s1),
        .c0   (fin_c0),
        .c1   (fin_c1),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );
endmodule

// File: rtl/cond_sum_adder_chk.sv
module cond_sum_adder_chk #(
    parameter int unsigned WIDTH = csa_pkg::CSA_DEF_WIDTH
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [WIDTH-1:0] fin_s0,
    input logic [WIDTH-1:0] fin_s1,
    input logic             fin_c0,
    input logic             fin_c1
);
    logic [WIDTH:0] ref_tot, ref_0, ref_1;
    logic [WIDTH-1:0] one_up;

    always_comb begin
        ref_tot = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        ref_0   = {1'b0, a} + {1'b0, b};
        ref_1   = ref_0 + {{WIDTH{1'b0}}, 1'b1};
        one_up  = fin_s0 + {{(WIDTH-1){1'b0}}, 1'b1};

        // R1
        a_r1_total_matches: assert ({cout, sum} == ref_tot)
            else $error("R1: {cout,sum}=%0h expected %0h", {cout, sum}, ref_tot);
        // R2
        a_r2_hyp0_result: assert ({fin_c0, fin_s0} == ref_0)
            else $error("R2: hyp0 %0h expected %0h", {fin_c0, fin_s0}, ref_0);
        // R3
        a_r3_hyp1_result: assert ({fin_c1, fin_s1} == ref_1)
            else $error("R3: hyp1 %0h expected %0h", {fin_c1, fin_s1}, ref_1);
        // R4
        a_r4_carry_monotone: assert (!fin_c0 || fin_c1)
            else $error("R4: hyp0 carry set but hyp1 carry clear");
        // R5
        a_r5_split_only_all_ones: assert ((fin_c0 == fin_c1) ||
                                          ((&fin_s0) && (fin_s1 == '0)))
            else $error("R5: carries split with s0=%0h s1=%0h", fin_s0, fin_s1);
        // R8
        a_r8_sums_one_apart: assert (fin_s1 == one_up)
            else $error("R8: s1=%0h expected %0h", fin_s1, one_up);
    end
endmodule

bind cond_sum_adder cond_sum_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a      (a),
    .b      (b),
    .cin    (cin),
    .sum    (sum),
    .cout   (cout),
    .fin_s0 (fin_s0),
    .fin_s1 (fin_s1),
    .fin_c0 (fin_c0),
    .fin_c1 (fin_c1)
);

// File: tb/cond_sum_adder_tb.sv
module cond_sum_adder_tb;
    localparam int unsigned W = 8;
    localparam int unsigned WATCHDOG_CYC = 200000;

    logic         clk = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cond_sum_adder #(.WIDTH(W)) u_dut (
        .a    (a),
        .b    (b),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s a=%0h b=%0h cin=%0b actual=%0h expected=%0h",
                     req, a, b, cin, got, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb_, input logic tc);
        a = ta; b = tb_; cin = tc;
        #1;
    endtask

    // R1: all-zero inputs give zero result
    task automatic t_zero();
        apply('0, '0, 1'b0);
        check("R1 zero", {cout, sum}, '0);
    endtask

    // R6: worked operand pair
    task automatic t_worked();
        apply(8'b00101101, 8'b10110110, 1'b0);
        check("R6 cin0", {cout, sum}, {1'b0, 8'b11100011});
        apply(8'b00101101, 8'b10110110, 1'b1);
        check("R6 cin1", {cout, sum}, {1'b0, 8'b11100100});
    endtask

    // R5 and R3 boundaries
    task automatic t_corners();
        apply(8'hFF, 8'h00, 1'b0);
        check("R5 ones cin0", {cout, sum}, 9'h0FF);
        apply(8'hFF, 8'h00, 1'b1);
        check("R5 ones cin1", {cout, sum}, 9'h100);
        apply(8'hFF, 8'hFF, 1'b1);
        check("R3 max", {cout, sum}, 9'h1FF);
        apply(8'h80, 8'h80, 1'b0);
        check("R2 top carry", {cout, sum}, 9'h100);
    endtask

    // R7: output follows input within one step, no stored state
    task automatic t_no_state();
        apply(8'h12, 8'h34, 1'b1);
        check("R7 first", {cout, sum}, 9'h047);
        a = 8'h01; b = 8'h01; cin = 1'b0;
        #1;
        check("R7 follow", {cout, sum}, 9'h002);
        apply(8'h12, 8'h34, 1'b1);
        check("R7 repeat", {cout, sum}, 9'h047);
    endtask

    // R1 R2 R3 R4 R5 R8: every operand pair, both carry-in values
    task automatic t_sweep();
        logic [W:0] r0, r1, e0, e1;
        int bad;
        bad = 0;
        for (int ia = 0; ia < (1 << W); ia++) begin
            for (int ib = 0; ib < (1 << W); ib++) begin
                e0 = 9'(ia + ib);
                e1 = 9'(ia + ib + 1);
                apply(W'(ia), W'(ib), 1'b0);
                r0 = {cout, sum};
                apply(W'(ia), W'(ib), 1'b1);
                r1 = {cout, sum};
                if (r0 !== e0) begin
                    bad++;
                    if (bad < 8) check("R2 sweep", r0, e0);
                end
                if (r1 !== e1) begin
                    bad++;
                    if (bad < 8) check("R3 sweep", r1, e1);
                end
                if (r0[W] && !r1[W]) begin
                    bad++;
                    if (bad < 8) check("R4 sweep", {8'h0, r1[W]}, 9'h1);
                end
                if ((r0[W] != r1[W]) && !((r0[W-1:0] == '1) && (r1 == 9'h100))) begin
                    bad++;
                    if (bad < 8) check("R5 sweep", r1, 9'h100);
                end
                if (r1[W-1:0] !== W'(r0[W-1:0] + 1'b1)) begin
                    bad++;
                    if (bad < 8) check("R8 sweep", {1'b0, r1[W-1:0]}, {1'b0, W'(r0[W-1:0] + 1'b1)});
                end
            end
        end
        check("R1 sweep mismatches", 9'(bad), 9'd0);
    endtask

    initial begin
        #3;
        t_zero();
        t_worked();
        t_corners();
        t_no_state();
        t_sweep();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG_CYC; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule